// File: doc/BRIEF.md
# Interval Timer Write Shadow Sequencer

This block listens passively to the I/O write traffic aimed at a three-channel interval timer of the 8254 kind. It keeps a copy of the programmed count bytes of each channel and of the last mode control word that reached each channel. Software can then rebuild the timer's programming after a power transition even though the timer's own registers cannot be read back. The block does no counting. It does not model the current-count latch or the timer outputs. The count bytes it keeps are the base values that were programmed, never the live count.

The copies are read through one 8-bit read-only port. A pointer selects one of nine entries. The port data always shows the entry under the pointer. Each read strobe moves the pointer on by one, and the pointer returns to the first entry after the ninth. A write strobe on the port returns the pointer to the first entry.

Each channel holds a copy of its access mode, taken from the snooped control words. This lets a count byte reach the correct low or high slot, including the alternating low/high mode.

Top module: `tmr_shadow_seq`

## Requirements
- R1: After reset every entry reads 00h and the pointer selects entry 0.
- R2: `port_rdata` shows the entry under the pointer. A cycle with `port_rd` high and `port_wr` low moves the pointer from entry k to entry k+1. Entries 0–5 are low byte then high byte of channels 0, 1 and 2, in that order. Entries 6, 7 and 8 are the control words of channels 0, 1 and 2.
- R3: A read while the pointer is on entry 8 returns the pointer to entry 0.
- R4: A cycle with `port_wr` high returns the pointer to entry 0, even if `port_rd` is also high in that cycle.
- R5: A snooped write to the control address sends the word to channel 0, 1 or 2 according to data bits 7:6 (00, 01, 10). That channel's control entry then reads data bits 5:0, with bits 7:6 read as 0.
- R6: A control word whose bits 7:6 are 11 (the read-back command) changes no entry and no channel state.
- R7: A control word whose bits 5:4 are 00 (the count latch command) changes no entry. It also leaves that channel's low/high alternation where it was.
- R8: When a channel's stored bits 5:4 are 01, a count write goes to its low byte. When they are 10, the count write goes to its high byte.
- R9: When a channel's stored bits 5:4 are 11, count writes go to the low byte and the high byte in turn, starting with the low byte. Any accepted control word to that channel starts the pair over at the low byte.
- R10: While a channel's stored bits 5:4 are 00 (as after reset), its count writes are ignored. An accepted control word leaves the stored count bytes unchanged.
- R11: Count writes for channel c are decoded at address 40h+c and control words at 43h. A snooped write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snoop_wr | input | 1 | Snooped I/O write strobe, one cycle per write |
| snoop_addr | input | SNOOP_AW | Snooped I/O write address |
| snoop_data | input | 8 | Snooped I/O write data |
| port_rd | input | 1 | Read strobe of the shadow port; moves the pointer on |
| port_wr | input | 1 | Write strobe of the shadow port; rewinds the pointer |
| port_rdata | output | 8 | Entry currently selected by the pointer |

## Verification
The assertions check the pointer on every cycle: its range, the one-step advance, the wrap after entry 8, the rewind on a port write (which wins over a read), and that it holds still when no strobe is present. They also check that the control entries always read 0 in bits 7:6, and that the port data stays steady in an idle cycle. What the stored bytes contain depends on the history of snooped writes, so only the bench scenarios can show it. These cover access-mode steering, the alternating low/high order and its restart, the latch and read-back commands being ignored, and writes to other addresses being ignored. The bench compares every value read against a model built from the requirements.

// File: rtl/tmr_shadow_pkg.sv
package tmr_shadow_pkg;

    localparam int CH_NUM  = 3;
    localparam int BYTE_W  = 8;
    localparam int CTL_W   = 6;
    localparam int ENT_NUM = 3 * CH_NUM;
    localparam int PTR_W   = $clog2(ENT_NUM);
    localparam int LAST_ENT = ENT_NUM - 1;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [CTL_W-1:0]  ctl;
        logic              hi_next;
    } chan_st_t;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } seq_st_t;

endpackage

// File: rtl/tmr_shadow_decode.sv
module tmr_shadow_decode
    import tmr_shadow_pkg::*;
#(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   CNT_BASE  = 'h40,
    parameter logic [AW-1:0]   CTRL_ADDR = 'h43
) (
    input  logic               snoop_wr,
    input  logic [AW-1:0]      snoop_addr,
    input  logic [BYTE_W-1:0]  snoop_data,
    output logic [CH_NUM-1:0]  cnt_we,
    output logic [CH_NUM-1:0]  ctl_we
);

    logic is_ctl;
    logic not_latch;

    always_comb begin
        is_ctl    = snoop_wr && (snoop_addr == CTRL_ADDR);
        not_latch = (acc_e'(snoop_data[5:4]) != ACC_LATCH);
        for (int c = 0; c < CH_NUM; c++) begin
            cnt_we[c] = snoop_wr && (snoop_addr == AW'(int'(CNT_BASE) + c));
            // channel select 11 (read-back) never matches a channel index
            ctl_we[c] = is_ctl && not_latch && (snoop_data[7:6] == 2'(c));
        end
    end

endmodule

// File: rtl/tmr_shadow_chan.sv
module tmr_shadow_chan
    import tmr_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] ctl_byte
);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl     = wdata[CTL_W-1:0];
            st_d.hi_next = 1'b0;
        end else if (cnt_we) begin
            unique case (acc_e'(st_q.ctl[5:4]))
                ACC_LO:   st_d.lo = wdata;
                ACC_HI:   st_d.hi = wdata;
                ACC_LOHI: begin
                    if (st_q.hi_next) st_d.hi = wdata;
                    else              st_d.lo = wdata;
                    st_d.hi_next = ~st_q.hi_next;
                end
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_byte  = st_q.lo;
    assign hi_byte  = st_q.hi;
    assign ctl_byte = {{(BYTE_W-CTL_W){1'b0}}, st_q.ctl};

endmodule

// File: rtl/tmr_shadow_rdseq.sv
module tmr_shadow_rdseq
    import tmr_shadow_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      port_rd,
    input  logic                      port_wr,
    input  logic [ENT_NUM*BYTE_W-1:0] ent_flat,
    output logic [BYTE_W-1:0]         rdata,
    output logic [PTR_W-1:0]          ptr
);

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (port_wr) begin
            st_d.ptr = '0;
        end else if (port_rd) begin
            if (st_q.ptr == PTR_W'(LAST_ENT)) st_d.ptr = '0;
            else                              st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr   = st_q.ptr;
    assign rdata = ent_flat[int'(st_q.ptr)*BYTE_W +: BYTE_W];

endmodule

// File: rtl/tmr_shadow_seq.sv
module tmr_shadow_seq
    import tmr_shadow_pkg::*;
#(
    parameter int              SNOOP_AW  = 16,
    parameter logic [SNOOP_AW-1:0] CNT_BASE  = 'h40,
    parameter logic [SNOOP_AW-1:0] CTRL_ADDR = 'h43
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snoop_wr,
    input  logic [SNOOP_AW-1:0] snoop_addr,
    input  logic [7:0]          snoop_data,
    input  logic                port_rd,
    input  logic                port_wr,
    output logic [7:0]          port_rdata
);

    logic [CH_NUM-1:0]         cnt_we;
    logic [CH_NUM-1:0]         ctl_we;
    logic [BYTE_W-1:0]         lo_b  [CH_NUM];
    logic [BYTE_W-1:0]         hi_b  [CH_NUM];
    logic [BYTE_W-1:0]         ctl_b [CH_NUM];
    logic [ENT_NUM*BYTE_W-1:0] ent_flat;
    logic [PTR_W-1:0]          rd_ptr;

    tmr_shadow_decode #(
        .AW        (SNOOP_AW),
        .CNT_BASE  (CNT_BASE),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .snoop_wr   (snoop_wr),
        .snoop_addr (snoop_addr),
        .snoop_data (snoop_data),
        .cnt_we     (cnt_we),
        .ctl_we     (ctl_we)
    );

    for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
        tmr_shadow_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_we   (cnt_we[c]),
            .ctl_we   (ctl_we[c]),
            .wdata    (snoop_data),
            .lo_byte  (lo_b[c]),
            .hi_byte  (hi_b[c]),
            .ctl_byte (ctl_b[c])
        );
        // read order: count pairs first, control words after all pairs
        assign ent_flat[(2*c)*BYTE_W   +: BYTE_W]        = lo_b[c];
        assign ent_flat[(2*c+1)*BYTE_W +: BYTE_W]        = hi_b[c];
        assign ent_flat[(2*CH_NUM+c)*BYTE_W +: BYTE_W]   = ctl_b[c];
    end

    tmr_shadow_rdseq u_rdseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_rd  (port_rd),
        .port_wr  (port_wr),
        .ent_flat (ent_flat),
        .rdata    (port_rdata),
        .ptr      (rd_ptr)
    );

endmodule

// File: rtl/tmr_shadow_chk.sv
module tmr_shadow_chk
    import tmr_shadow_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             snoop_wr,
    input logic             port_rd,
    input logic             port_wr,
    input logic [7:0]       port_rdata,
    input logic [PTR_W-1:0] rd_ptr
);

    a_r1_ptr_at_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_ptr == '0));

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_ptr) < ENT_NUM);

    a_r2_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr && rd_ptr != PTR_W'(LAST_ENT))
        |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_rd && !port_wr) |=> $stable(rd_ptr));

    a_r2_idle_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_rd && !port_wr && !snoop_wr) |=> $stable(port_rdata));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr && rd_ptr == PTR_W'(LAST_ENT)) |=> (rd_ptr == '0));

    a_r4_write_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (rd_ptr == '0));

    a_r5_ctl_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_ptr) >= 2*CH_NUM) |-> (port_rdata[7:6] == 2'b00));

endmodule

bind tmr_shadow_seq tmr_shadow_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snoop_wr   (snoop_wr),
    .port_rd    (port_rd),
    .port_wr    (port_wr),
    .port_rdata (port_rdata),
    .rd_ptr     (rd_ptr)
);

// File: tb/tmr_shadow_seq_tb.sv
module tmr_shadow_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snoop_wr = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic [7:0]  snoop_data = '0;
    logic        port_rd = 1'b0;
    logic        port_wr = 1'b0;
    logic [7:0]  port_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_lo [3];
    logic [7:0] m_hi [3];
    logic [5:0] m_ctl [3];
    bit         m_tog [3];
    int         m_ptr;

    always #4 clk = ~clk;

    tmr_shadow_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .snoop_wr   (snoop_wr),
        .snoop_addr (snoop_addr),
        .snoop_data (snoop_data),
        .port_rd    (port_rd),
        .port_wr    (port_wr),
        .port_rdata (port_rdata)
    );

    function automatic logic [7:0] exp_entry(int p);
        if (p < 6) return (p % 2 == 0) ? m_lo[p/2] : m_hi[p/2];
        return {2'b00, m_ctl[p-6]};
    endfunction

    task automatic model_update(bit w, int a, logic [7:0] d, bit rd, bit pw);
        if (w) begin
            if (a >= 'h40 && a <= 'h42) begin
                int c = a - 'h40;
                case (m_ctl[c][5:4])
                    2'b01: m_lo[c] = d;
                    2'b10: m_hi[c] = d;
                    2'b11: begin
                        if (m_tog[c]) m_hi[c] = d; else m_lo[c] = d;
                        m_tog[c] = ~m_tog[c];
                    end
                    default: ;
                endcase
            end else if (a == 'h43 && d[7:6] != 2'b11 && d[5:4] != 2'b00) begin
                m_ctl[d[7:6]] = d[5:0];
                m_tog[d[7:6]] = 1'b0;
            end
        end
        if (pw)      m_ptr = 0;
        else if (rd) m_ptr = (m_ptr == 8) ? 0 : m_ptr + 1;
    endtask

    // check the presented entry, then drive one cycle of stimulus
    task automatic step(string tag, bit w, int a, logic [7:0] d, bit rd, bit pw);
        logic [7:0] e;
        @(negedge clk);
        e = exp_entry(m_ptr);
        checks++;
        if (port_rdata !== e) begin
            failures++;
            $display("FAIL %s entry=%0d actual=%02h expected=%02h", tag, m_ptr, port_rdata, e);
        end
        snoop_wr = w; snoop_addr = 16'(a); snoop_data = d; port_rd = rd; port_wr = pw;
        @(posedge clk);
        model_update(w, a, d, rd, pw);
    endtask

    task automatic snoop(string tag, int a, logic [7:0] d);
        step(tag, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic read_all(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic rewind(string tag);
        step(tag, 1'b0, 0, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_lo[c] = '0; m_hi[c] = '0; m_ctl[c] = '0; m_tog[c] = 1'b0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        read_all("R1", 9);                 // reset values, then wrap back to 0
        read_all("R3", 3);
        rewind("R4");

        snoop("R10", 'h40, 8'h55);         // ignored: no mode yet
        snoop("R11", 'h44, 8'h34);         // outside the decoded range
        snoop("R11", 'h3F, 8'h34);
        read_all("R10", 9);

        snoop("R5", 'h43, 8'h34);          // ch0 low/high pair
        snoop("R9", 'h40, 8'h12);
        snoop("R9", 'h40, 8'h34);
        snoop("R5", 'h43, 8'h50);          // ch1 low only
        snoop("R8", 'h41, 8'hAB);
        snoop("R8", 'h41, 8'hAC);
        snoop("R5", 'h43, 8'hA6);          // ch2 high only
        snoop("R8", 'h42, 8'hCD);
        rewind("R4");
        read_all("R2", 9);

        snoop("R7", 'h40, 8'h77);          // low byte, next goes high
        snoop("R7", 'h43, 8'h00);          // latch: no effect
        snoop("R7", 'h40, 8'h88);          // must land in high byte
        snoop("R9", 'h40, 8'h99);          // low
        snoop("R10", 'h43, 8'h36);         // restart pair, bytes kept
        snoop("R9", 'h40, 8'h11);          // low again
        snoop("R6", 'h43, 8'hFE);          // read-back: no effect
        snoop("R6", 'h43, 8'hC2);
        rewind("R4");
        read_all("R6", 9);

        read_all("R2", 4);
        step("R4", 1'b0, 0, 8'h00, 1'b1, 1'b1);  // write wins over read
        read_all("R3", 12);

        for (int i = 0; i < 3000; i++) begin
            int sel = int'($urandom_range(0, 9));
            int a = (sel < 6) ? 'h40 + (sel % 4) : ((sel == 6) ? 'h44 : 'h3F);
            bit w = ($urandom_range(0, 2) != 0);
            bit rd = ($urandom_range(0, 1) != 0);
            bit pw = ($urandom_range(0, 15) == 0);
            step("R2", w, a, 8'($urandom()), rd, pw);
        end
        step("R2", 1'b0, 0, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule